// File: doc/BRIEF.md
# Status Variable Readback Responder

This block sits behind the byte-level engine of an I2C target inside a motor controller. It answers read transfers that return status variables, RAM settings or EEPROM settings. A write transfer first sets up a read pointer. The bytes of the following read transfer are then streamed out of a byte-addressed storage read port, starting at the pointer, in the order the storage holds them, so multi-byte values go out least significant byte first.

There are two ways to set up the pointer. A long opcode takes an explicit offset byte and allows up to fifteen bytes per read. A short opcode names a fixed variable position within the opcode value itself and allows one or two bytes. A few short opcodes also request a one-cycle clear strobe for the variable they read. That strobe is issued only once the last affected byte has been handed to the I2C engine, so the value sent out is always the value from before the clear.

Received bytes come in on a valid/ready stream. `rx_ready` is high whenever no read transfer is open, and a byte is taken in any cycle where `rx_valid` and `rx_ready` are both high. Outgoing bytes leave on a valid/ready stream. `tx_valid` is high for the whole of a read transfer, and the pointer advances only in cycles where `tx_ready` is high. While `tx_ready` is low, `tx_data` and the pointer hold. Transfer framing uses plain pulses: `wr_begin`, `rd_begin` and `xfer_end`.

Top module: `var_readback_responder`

## Requirements
- R1: Opcode 0xE5, 0xEA or 0xE3 followed by an offset byte selects storage space 0 (variables), 1 (RAM settings) or 2 (EEPROM settings) respectively on `mem_space`, starting at that offset, with a 15-byte allowance.
- R2: During a read transfer, the byte with index n (counting from 0) is read from `mem_addr` = offset + n, wrapping modulo 256. Any byte at index 15 or above, or at or beyond the allowance, is sent as 0x00.
- R3: Reads set up by a long opcode never raise any clear strobe.
- R4: A write holding only a long opcode, when that opcode equals the one used by the current setup, keeps the offset. A bare long opcode that differs from it selects that opcode's space at offset 0.
- R5: Opcode 0xA1+k, for k from 0 to 31, selects variable space at offset k with a two-byte allowance.
- R6: Opcode 0x81+k, for k from 0 to 31, selects variable space at offset k with a one-byte allowance.
- R7: Opcode 0xB3 (offset 0x12) or 0xB5 (offset 0x14) pulses `clr_halt` or `clr_occur` respectively for one cycle, in the cycle after the handshake of the second byte. A read that stops before that byte pulses nothing.
- R8: Opcode 0xEC selects variable offset `CHOP_OFS` (default 0x20) with a one-byte allowance, and pulses `clr_chop` for one cycle after that byte's handshake.
- R9: Unrecognised opcodes, and any bytes after the ones a command uses, leave the setup unchanged.
- R10: After reset, `tx_valid` and every clear strobe are low, `rx_ready` is high, and the setup is variable space, offset 0, with a 15-byte allowance.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `mem_addr` stay unchanged, and `rx_ready` stays low for the whole read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_begin | input | 1 | Pulse: an addressed write transfer starts |
| rd_begin | input | 1 | Pulse: an addressed read transfer starts |
| xfer_end | input | 1 | Pulse: the current transfer has ended |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Responder accepts a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte available for sending |
| tx_ready | input | 1 | Engine takes the byte this cycle |
| tx_data | output | 8 | Byte to send |
| mem_space | output | 2 | Storage space select (0 variables, 1 RAM, 2 EEPROM) |
| mem_addr | output | ADDR_W | Storage byte address |
| mem_rdata | input | 8 | Storage byte, combinational from space and address |
| clr_halt | output | 1 | One-cycle clear strobe, halting error flags |
| clr_occur | output | 1 | One-cycle clear strobe, occurred error flags |
| clr_chop | output | 1 | One-cycle clear strobe, chopping occurrence count |

## Verification
Setup registers load on the clock edge that takes a received byte, or on the edge of `xfer_end` for a bare opcode. The first outgoing byte is therefore valid in the cycle after `rd_begin`. Each later byte appears in the cycle after the previous handshake, because `tx_data` follows the storage read port combinationally. A clear strobe is high for exactly the one cycle after the final affected handshake. The bench drives inputs on falling edges and checks `tx_data` shortly after it raises `tx_ready`, which is before the handshake edge. It counts strobe pulses on every rising edge and compares those counts once the transfer has closed.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  localparam int LEN_W = 5;

  typedef enum logic [1:0] {SP_VAR = 2'd0, SP_RAM = 2'd1, SP_EEP = 2'd2} space_e;
  typedef enum logic [1:0] {CLR_NONE, CLR_HALT, CLR_OCCUR, CLR_CHOP} clr_e;

  localparam logic [7:0] OP_VARS   = 8'hE5;
  localparam logic [7:0] OP_RAM    = 8'hEA;
  localparam logic [7:0] OP_EEP    = 8'hE3;
  localparam logic [7:0] OP_CHOP   = 8'hEC;
  localparam logic [7:0] OP_HALT2  = 8'hB3;
  localparam logic [7:0] OP_OCCUR2 = 8'hB5;
  localparam logic [7:0] SHORT1_LO = 8'h81;
  localparam logic [7:0] SHORT2_LO = 8'hA1;
  localparam logic [7:0] SHORT2_HI = 8'hC0;

  typedef struct packed {
    space_e           space;
    logic [7:0]       ofs;
    logic [LEN_W-1:0] len;
    clr_e             clr;
  } setup_t;

  function automatic logic is_long_op(input logic [7:0] op);
    return (op == OP_VARS) || (op == OP_RAM) || (op == OP_EEP);
  endfunction

  function automatic space_e space_of(input logic [7:0] op);
    case (op)
      OP_RAM:  return SP_RAM;
      OP_EEP:  return SP_EEP;
      default: return SP_VAR;
    endcase
  endfunction
endpackage

// File: rtl/vrr_cmd_decode.sv
module vrr_cmd_decode
  import vrr_pkg::*;
#(
  parameter int         MAX_READ = 15,
  parameter logic [7:0] CHOP_OFS = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_begin,
  input  logic       xfer_end,
  input  logic       rx_fire,
  input  logic [7:0] rx_data,
  output setup_t     setup
);
  typedef enum logic [1:0] {EXP_OP, EXP_OFS, SKIP} phase_e;

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_READ);

  phase_e     phase;
  logic [7:0] pend_op;
  logic [7:0] cur_op;

  logic             short_hit;
  setup_t           short_setup;

  always_comb begin
    short_hit         = 1'b0;
    short_setup.space = SP_VAR;
    short_setup.ofs   = 8'h00;
    short_setup.len   = LEN_W'(1);
    short_setup.clr   = CLR_NONE;
    if (rx_data == OP_CHOP) begin
      short_hit         = 1'b1;
      short_setup.ofs   = CHOP_OFS;
      short_setup.clr   = CLR_CHOP;
    end else if (rx_data >= SHORT2_LO && rx_data <= SHORT2_HI) begin
      short_hit         = 1'b1;
      short_setup.ofs   = rx_data - SHORT2_LO;
      short_setup.len   = LEN_W'(2);
      if (rx_data == OP_HALT2)  short_setup.clr = CLR_HALT;
      if (rx_data == OP_OCCUR2) short_setup.clr = CLR_OCCUR;
    end else if (rx_data >= SHORT1_LO && rx_data < SHORT2_LO) begin
      short_hit         = 1'b1;
      short_setup.ofs   = rx_data - SHORT1_LO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= SKIP;
      pend_op     <= 8'h00;
      cur_op      <= 8'h00;
      setup.space <= SP_VAR;
      setup.ofs   <= 8'h00;
      setup.len   <= FULL_LEN;
      setup.clr   <= CLR_NONE;
    end else if (wr_begin) begin
      phase <= EXP_OP;
    end else if (rx_fire) begin
      case (phase)
        EXP_OP: begin
          if (is_long_op(rx_data)) begin
            pend_op <= rx_data;
            phase   <= EXP_OFS;
          end else begin
            if (short_hit) begin
              setup  <= short_setup;
              cur_op <= 8'h00;
            end
            phase <= SKIP;
          end
        end
        EXP_OFS: begin
          setup.space <= space_of(pend_op);
          setup.ofs   <= rx_data;
          setup.len   <= FULL_LEN;
          setup.clr   <= CLR_NONE;
          cur_op      <= pend_op;
          phase       <= SKIP;
        end
        default: phase <= SKIP;
      endcase
    end else if (xfer_end) begin
      if (phase == EXP_OFS && pend_op != cur_op) begin
        setup.space <= space_of(pend_op);
        setup.ofs   <= 8'h00;
        setup.len   <= FULL_LEN;
        setup.clr   <= CLR_NONE;
        cur_op      <= pend_op;
      end
      phase <= SKIP;
    end
  end

  // R1: the offset byte following a long opcode becomes the start offset
  assert_offset_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !wr_begin && phase == EXP_OFS) |=> (setup.ofs == $past(rx_data)));

  // R4: a bare repeat of the active long opcode keeps the offset
  assert_bare_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !wr_begin && !rx_fire && phase == EXP_OFS && pend_op == cur_op)
      |=> $stable(setup.ofs));

  // R9: bytes beyond the command leave the setup untouched
  assert_extra_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !wr_begin && phase == SKIP) |=> $stable(setup));
endmodule

// File: rtl/vrr_read_stream.sv
module vrr_read_stream
  import vrr_pkg::*;
#(
  parameter int MAX_READ = 15,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_begin,
  input  logic              xfer_end,
  input  setup_t            setup,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic [1:0]        mem_space,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              last_taken
);
  localparam int CW = $clog2(MAX_READ + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_READ);

  logic          active;
  logic [CW-1:0] cnt;
  logic          fire;
  logic          in_range;

  assign fire      = active && tx_ready;
  assign in_range  = (LEN_W'(cnt) < setup.len) && (cnt < CNT_MAX);
  assign tx_valid  = active;
  assign tx_data   = in_range ? mem_rdata : 8'h00;
  assign mem_space = setup.space;
  assign mem_addr  = ADDR_W'(setup.ofs) + ADDR_W'(cnt);
  assign last_taken = fire && in_range && (LEN_W'(cnt) == setup.len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (rd_begin) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (xfer_end) begin
      active <= 1'b0;
    end else if (fire && cnt != CNT_MAX) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R2: each accepted byte advances the pointer by exactly one
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rd_begin && !xfer_end && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CW'(1)));

  // R11: without a handshake the pointer holds
  assert_hold_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tx_ready && !rd_begin && !xfer_end) |=> $stable(mem_addr));
endmodule

// File: rtl/vrr_clear_ctrl.sv
module vrr_clear_ctrl
  import vrr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic last_taken,
  input  clr_e kind,
  output logic clr_halt,
  output logic clr_occur,
  output logic clr_chop
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_halt  <= 1'b0;
      clr_occur <= 1'b0;
      clr_chop  <= 1'b0;
    end else begin
      clr_halt  <= last_taken && (kind == CLR_HALT);
      clr_occur <= last_taken && (kind == CLR_OCCUR);
      clr_chop  <= last_taken && (kind == CLR_CHOP);
    end
  end

  // R7: at most one clear strobe at a time, each lasting one cycle
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_halt, clr_occur, clr_chop}));
  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_halt || clr_occur || clr_chop) |=> !(clr_halt || clr_occur || clr_chop));
endmodule

// File: rtl/var_readback_responder.sv
module var_readback_responder
  import vrr_pkg::*;
#(
  parameter int         MAX_READ = 15,
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] CHOP_OFS = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic              rd_begin,
  input  logic              xfer_end,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic [1:0]        mem_space,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              clr_halt,
  output logic              clr_occur,
  output logic              clr_chop
);
  setup_t setup;
  logic   last_taken;
  logic   rx_fire;

  assign rx_ready = !tx_valid;
  assign rx_fire  = rx_valid && rx_ready;

  vrr_cmd_decode #(.MAX_READ(MAX_READ), .CHOP_OFS(CHOP_OFS)) u_decode (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .xfer_end(xfer_end),
    .rx_fire(rx_fire), .rx_data(rx_data), .setup(setup)
  );

  vrr_read_stream #(.MAX_READ(MAX_READ), .ADDR_W(ADDR_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .rd_begin(rd_begin), .xfer_end(xfer_end),
    .setup(setup), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .last_taken(last_taken)
  );

  vrr_clear_ctrl u_clear (
    .clk(clk), .rst_n(rst_n), .last_taken(last_taken), .kind(setup.clr),
    .clr_halt(clr_halt), .clr_occur(clr_occur), .clr_chop(clr_chop)
  );

  // R8: a clear strobe always follows a byte handshake
  assert_clear_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_halt || clr_occur || clr_chop) |-> $past(tx_valid && tx_ready));

  // R11: the setup cannot change inside an open read transfer
  assert_setup_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && $past(tx_valid)) |-> $stable(mem_space));
endmodule

// File: tb/var_readback_responder_bench.sv
`timescale 1ns/1ps
module var_readback_responder_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_begin = 0, rd_begin = 0, xfer_end = 0;
  logic rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, tx_valid, clr_halt, clr_occur, clr_chop;
  logic [7:0] tx_data, mem_rdata;
  logic [1:0] mem_space;
  logic [7:0] mem_addr;

  int total = 0, bad = 0;
  int n_halt = 0, n_occur = 0, n_chop = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  var_readback_responder u_var_readback_responder (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .rd_begin(rd_begin),
    .xfer_end(xfer_end), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .clr_halt(clr_halt), .clr_occur(clr_occur), .clr_chop(clr_chop)
  );

  function automatic logic [7:0] model(input logic [1:0] sp, input logic [7:0] a);
    return {sp, 6'b0} ^ a ^ 8'h3C;
  endfunction

  assign mem_rdata = model(mem_space, mem_addr);

  always @(posedge clk) if (rst_n) begin
    n_halt  <= n_halt + int'(clr_halt);
    n_occur <= n_occur + int'(clr_occur);
    n_chop  <= n_chop + int'(clr_chop);
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_xfer(input int n, input logic [7:0] b0, input logic [7:0] b1 = 0,
                         input logic [7:0] b2 = 0);
    logic [7:0] bytes [3];
    bytes = '{b0, b1, b2};
    @(negedge clk) wr_begin = 1;
    @(negedge clk) wr_begin = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = bytes[i];
      @(negedge clk);
    end
    rx_valid = 0;
    xfer_end = 1;
    @(negedge clk) xfer_end = 0;
  endtask

  // reads n bytes, checks each and the strobe deltas
  task automatic rd_xfer(input string req, input int n, input logic [1:0] sp,
                         input logic [7:0] ofs, input int len, input int clr);
    int h0 = n_halt, o0 = n_occur, c0 = n_chop;
    logic [7:0] exp;
    @(negedge clk) rd_begin = 1;
    @(negedge clk) rd_begin = 0;
    for (int i = 0; i < n; i++) begin
      tx_ready = 1;
      #1;
      exp = (i < len && i < 15) ? model(sp, ofs + 8'(i)) : 8'h00;
      check(req, tx_data, exp);
      @(negedge clk);
    end
    tx_ready = 0;
    xfer_end = 1;
    @(negedge clk) xfer_end = 0;
    @(negedge clk);
    check({req, " halt strobes"},  n_halt - h0,  (clr == 1 && n >= len) ? 1 : 0);
    check({req, " occur strobes"}, n_occur - o0, (clr == 2 && n >= len) ? 1 : 0);
    check({req, " chop strobes"},  n_chop - c0,  (clr == 3 && n >= len) ? 1 : 0);
  endtask

  typedef struct packed {
    logic [7:0] op;
    logic       has_ofs;
    logic [7:0] ofs;
    logic [4:0] nread;
    logic [1:0] sp;
    logic [7:0] eofs;
    logic [4:0] elen;
    logic [1:0] clr;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{8'hE5, 1'b1, 8'h10, 5'd4,  2'd0, 8'h10, 5'd15, 2'd0},  // R1 R3
    '{8'hEA, 1'b1, 8'h05, 5'd3,  2'd1, 8'h05, 5'd15, 2'd0},  // R1
    '{8'hE3, 1'b1, 8'hFE, 5'd4,  2'd2, 8'hFE, 5'd15, 2'd0},  // R2 wrap
    '{8'hE5, 1'b1, 8'h03, 5'd17, 2'd0, 8'h03, 5'd15, 2'd0},  // R2 filler
    '{8'hA5, 1'b0, 8'h00, 5'd3,  2'd0, 8'h04, 5'd2,  2'd0},  // R5
    '{8'h88, 1'b0, 8'h00, 5'd2,  2'd0, 8'h07, 5'd1,  2'd0},  // R6
    '{8'hB3, 1'b0, 8'h00, 5'd2,  2'd0, 8'h12, 5'd2,  2'd1},  // R7
    '{8'hB5, 1'b0, 8'h00, 5'd3,  2'd0, 8'h14, 5'd2,  2'd2},  // R7
    '{8'hEC, 1'b0, 8'h00, 5'd1,  2'd0, 8'h20, 5'd1,  2'd3},  // R8
    '{8'hC0, 1'b0, 8'h00, 5'd2,  2'd0, 8'h1F, 5'd2,  2'd0},  // R5 top k
    '{8'h81, 1'b0, 8'h00, 5'd1,  2'd0, 8'h00, 5'd1,  2'd0}   // R6 k=0
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 tx_valid", tx_valid, 0);
    check("R10 rx_ready", rx_ready, 1);
    check("R10 strobes", {clr_halt, clr_occur, clr_chop}, 0);
    @(negedge clk) rst_n = 1;
    check("R10 mem_space", mem_space, 0);
    check("R10 mem_addr", mem_addr, 0);
    rd_xfer("R10 default setup", 16, 2'd0, 8'h00, 15, 0);

    foreach (VECS[i]) begin
      if (VECS[i].has_ofs) wr_xfer(2, VECS[i].op, VECS[i].ofs);
      else                 wr_xfer(1, VECS[i].op);
      rd_xfer($sformatf("vec%0d R1 R2 R3 R5 R6 R7 R8", i), int'(VECS[i].nread),
              VECS[i].sp, VECS[i].eofs, int'(VECS[i].elen), int'(VECS[i].clr));
    end

    // R4 bare repeat keeps the offset, a different bare opcode restarts at 0
    wr_xfer(2, 8'hE5, 8'h30);
    wr_xfer(1, 8'hE5);
    rd_xfer("R4 bare same", 2, 2'd0, 8'h30, 15, 0);
    wr_xfer(1, 8'hEA);
    rd_xfer("R4 bare other", 2, 2'd1, 8'h00, 15, 0);

    // R9 unknown opcode and trailing bytes
    wr_xfer(2, 8'hE3, 8'h40);
    wr_xfer(1, 8'h42);
    rd_xfer("R9 unknown op", 2, 2'd2, 8'h40, 15, 0);
    wr_xfer(3, 8'hE5, 8'h22, 8'h99);
    rd_xfer("R9 trailing byte", 2, 2'd0, 8'h22, 15, 0);

    // R7 partial read pulses nothing
    wr_xfer(1, 8'hB3);
    rd_xfer("R7 partial", 1, 2'd0, 8'h12, 2, 1);

    // R11 back-pressure holds data, rx_ready low during read
    wr_xfer(2, 8'hE5, 8'h50);
    @(negedge clk) rd_begin = 1;
    @(negedge clk) rd_begin = 0;
    tx_ready = 1;
    @(negedge clk) tx_ready = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 held data", tx_data, model(2'd0, 8'h51));
      check("R11 held addr", mem_addr, 8'h51);
      check("R11 rx_ready low", rx_ready, 0);
    end
    xfer_end = 1;
    @(negedge clk) xfer_end = 0;
    check("R11 rx_ready back", rx_ready, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule